// File: doc/BRIEF.md
# Low-Power Operating Mode Controller

This block tracks the operating mode of a small processor that runs from two oscillators: a fast one and a slow one. Software asks for a mode change by writing mode bits. The bits are idle, timebase halt, stop, slow-oscillator enable, system-clock select and fast-oscillator enable. The controller walks a graph of eleven states and decides from the current state alone which oscillators run and which clock domains are gated. The states are a warm-up state and ten operating modes, split into a single-clock family and a dual-clock family. Each family has its own idle and sleep variants. Requests that are not legal in the current mode leave it unchanged.

Software wakes the processor in one of three ways, depending on the mode:
- An interrupt ends an idle or sleep mode.
- A falling edge of the selected timebase clock ends the two timebase-halt modes.
- An external stop-release signal ends stop.

Leaving stop toward a fast gear passes through a counted warm-up. During the warm-up the CPU clock is held off and a busy flag is high. The same warm-up runs after reset. The controller also holds the choice between the internal and the external fast clock source. That choice can be changed only while a fast gear runs.

Top module: `pwr_mode_ctl`

## Requirements
- R1: While reset is asserted, and after it is released, `mode` is 0 (warm-up) with `warm_busy` = 1. Reset release takes two clock edges to pass through the reset synchronizer. After that the warm-up lasts WARM_CYCLES cycles, and then `mode` becomes 1 (fast single-clock run).
- R2: The idle strobe moves mode 1 to 6, mode 2 to 7, and mode 3 to 9. An asserted `irq_pend` returns mode 6 to 1, mode 7 to 2, and mode 9 to 3.
- R3: The timebase-halt strobe moves mode 1 to 5 and mode 3 to 8. Modes 5 and 8 ignore `irq_pend`. A falling edge of `tb_clk` moves mode 5 back to 1 and mode 8 back to 3.
- R4: A write of 1 to the slow-oscillator bit moves mode 1 to 2. A write of 0 moves mode 2 to 1.
- R5: A write of 1 to the clock-select bit moves mode 2 to 4, and a write of 0 moves mode 4 to 2. A write of 0 to the fast-oscillator bit moves mode 4 to 3, and a write of 1 moves mode 3 to 4.
- R6: The stop strobe in any of the modes 1 to 4 enters mode 10. When the stop request came from mode 1 or 2, `stop_rel` starts a warm-up (mode 0, busy) that lasts WARM_CYCLES cycles and then returns to that same mode.
- R7: When the stop request came from mode 3 or 4, `stop_rel` moves mode 10 directly to mode 3 with no warm-up.
- R8: A source write sets `hf_src_ext` to `hfsrc_val` only in modes 1 and 2. In every other mode the write has no effect. The reset value is 0 (internal source).
- R9: A request that is not legal in the current mode is ignored. Examples: timebase halt in mode 2, idle in mode 4. When several requests arrive in the same cycle, the order of precedence is stop, then timebase halt, then idle, then the clock-select and oscillator writes.
- R10: The outputs depend on the mode as follows:
  - `cpu_clk_en` is 1 only in modes 1 to 4.
  - `periph_clk_en` is 1 in every mode except 0 and 10.
  - `hf_osc_en` is 0 in modes 3, 8, 9 and 10.
  - `lf_osc_en` is 1 in modes 2, 3, 4, 7, 8 and 9, and also during a warm-up that returns to mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_idle | input | 1 | Idle request strobe |
| wr_tbhalt | input | 1 | Timebase-halt request strobe |
| wr_stop | input | 1 | Stop request strobe |
| lfosc_wr | input | 1 | Slow-oscillator enable write strobe |
| lfosc_val | input | 1 | Value written to the slow-oscillator enable bit |
| sysck_wr | input | 1 | System-clock select write strobe |
| sysck_val | input | 1 | Value written to the clock-select bit (1 = slow clock) |
| hfosc_wr | input | 1 | Fast-oscillator enable write strobe |
| hfosc_val | input | 1 | Value written to the fast-oscillator enable bit |
| hfsrc_wr | input | 1 | Fast-source select write strobe |
| hfsrc_val | input | 1 | Value written to the fast-source select bit (1 = external) |
| irq_pend | input | 1 | Interrupt pending |
| stop_rel | input | 1 | Stop release request |
| tb_clk | input | 1 | Selected timebase source clock |
| mode | output | 4 | Current state: 0 warm-up, 1 NORMAL1, 2 NORMAL2, 3 SLOW1, 4 SLOW2, 5 IDLE0, 6 IDLE1, 7 IDLE2, 8 SLEEP0, 9 SLEEP1, 10 STOP |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| hf_osc_en | output | 1 | Fast oscillator enable |
| lf_osc_en | output | 1 | Slow oscillator enable |
| hf_src_ext | output | 1 | Fast source is external |
| warm_busy | output | 1 | Warm-up in progress |

## Verification
Strobes, `irq_pend` and `stop_rel` act on the first clock edge that sees them, and every output is decoded from registered state, so each result of these requests is checked at the falling edge that follows that first rising edge. A fall of `tb_clk` passes through two synchronizer stages and an edge register, so the wake from modes 5 and 8 is due on the third rising edge. The bench checks that the mode has not changed after two edges and has changed after three. A warm-up lasts exactly WARM_CYCLES edges from the edge that entered it, and reset release adds two synchronizer edges in front of it. The bench samples the last busy cycle and the first run cycle on both sides of that boundary.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [3:0] {
    M_WARM   = 4'd0,
    M_N1     = 4'd1,
    M_N2     = 4'd2,
    M_S1     = 4'd3,
    M_S2     = 4'd4,
    M_IDLE0  = 4'd5,
    M_IDLE1  = 4'd6,
    M_IDLE2  = 4'd7,
    M_SLEEP0 = 4'd8,
    M_SLEEP1 = 4'd9,
    M_STOP   = 4'd10
  } mode_e;
endpackage

// File: rtl/pmc_tb_edge.sv
module pmc_tb_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tb_clk,
  output logic tb_fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], tb_clk};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign tb_fall = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/pmc_warmup.sv
module pmc_warmup #(
  parameter int WARM_CYCLES = 16,
  localparam int CW = $clog2(WARM_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic busy,
  output logic done
);
  localparam logic [CW-1:0] LAST = CW'(WARM_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load | (busy & (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load)        cnt_d = LAST;
    else if (cnt_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= LAST;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = busy & (cnt_q == '0);

  // R1/R6: a freshly loaded warm-up cannot end on the next cycle
  p_warm_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !done);
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_idle,
  input  logic  wr_tbhalt,
  input  logic  wr_stop,
  input  logic  lfosc_wr,
  input  logic  lfosc_val,
  input  logic  sysck_wr,
  input  logic  sysck_val,
  input  logic  hfosc_wr,
  input  logic  hfosc_val,
  input  logic  irq_pend,
  input  logic  stop_rel,
  input  logic  tb_fall,
  input  logic  warm_done,
  output logic  warm_load,
  output mode_e st,
  output logic  cpu_clk_en,
  output logic  periph_clk_en,
  output logic  hf_osc_en,
  output logic  lf_osc_en
);
  mode_e st_q, st_d, ret_q, ret_d;
  logic  running;

  assign running = (st_q == M_N1) | (st_q == M_N2) | (st_q == M_S1) | (st_q == M_S2);

  always_comb begin
    st_d  = st_q;
    ret_d = ret_q;
    case (st_q)
      M_WARM: if (warm_done) st_d = ret_q;
      M_N1: begin
        if (wr_stop)                    begin st_d = M_STOP; ret_d = M_N1; end
        else if (wr_tbhalt)             st_d = M_IDLE0;
        else if (wr_idle)               st_d = M_IDLE1;
        else if (lfosc_wr && lfosc_val) st_d = M_N2;
      end
      M_N2: begin
        if (wr_stop)                     begin st_d = M_STOP; ret_d = M_N2; end
        else if (wr_idle)                st_d = M_IDLE2;
        else if (lfosc_wr && !lfosc_val) st_d = M_N1;
        else if (sysck_wr && sysck_val)  st_d = M_S2;
      end
      M_S2: begin
        if (wr_stop)                     begin st_d = M_STOP; ret_d = M_S1; end
        else if (sysck_wr && !sysck_val) st_d = M_N2;
        else if (hfosc_wr && !hfosc_val) st_d = M_S1;
      end
      M_S1: begin
        if (wr_stop)                    begin st_d = M_STOP; ret_d = M_S1; end
        else if (wr_tbhalt)             st_d = M_SLEEP0;
        else if (wr_idle)               st_d = M_SLEEP1;
        else if (hfosc_wr && hfosc_val) st_d = M_S2;
      end
      M_IDLE0:  if (tb_fall)  st_d = M_N1;
      M_IDLE1:  if (irq_pend) st_d = M_N1;
      M_IDLE2:  if (irq_pend) st_d = M_N2;
      M_SLEEP0: if (tb_fall)  st_d = M_S1;
      M_SLEEP1: if (irq_pend) st_d = M_S1;
      M_STOP:   if (stop_rel) st_d = (ret_q == M_S1) ? M_S1 : M_WARM;
      default:  st_d = M_WARM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= M_WARM;
      ret_q <= M_N1;
    end else begin
      st_q  <= st_d;
      ret_q <= ret_d;
    end
  end

  assign warm_load = (st_d == M_WARM) & (st_q != M_WARM);
  assign st        = st_q;

  always_comb begin
    cpu_clk_en    = running;
    periph_clk_en = (st_q != M_WARM) & (st_q != M_STOP);
    hf_osc_en     = !((st_q == M_S1) | (st_q == M_SLEEP0) |
                      (st_q == M_SLEEP1) | (st_q == M_STOP));
    lf_osc_en     = (st_q == M_N2) | (st_q == M_S1) | (st_q == M_S2) |
                    (st_q == M_IDLE2) | (st_q == M_SLEEP0) | (st_q == M_SLEEP1) |
                    ((st_q == M_WARM) & (ret_q == M_N2));
  end

  p_idle_wake_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == M_IDLE1 && irq_pend) |=> st_q == M_N1);
  p_tb_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == M_IDLE0 && tb_fall) |=> st_q == M_N1);
  p_stop_warm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == M_STOP && stop_rel && ret_q != M_S1) |=> st_q == M_WARM);
  p_stop_slow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == M_STOP && stop_rel && ret_q == M_S1) |=> st_q == M_S1);
  p_stop_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && wr_stop) |=> st_q == M_STOP);
  p_no_halt_n2_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == M_N2 && wr_tbhalt) |=> st_q != M_IDLE0);
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pmc_pkg::*;
#(
  parameter int WARM_CYCLES = 16,
  parameter int TB_SYNC     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_idle,
  input  logic       wr_tbhalt,
  input  logic       wr_stop,
  input  logic       lfosc_wr,
  input  logic       lfosc_val,
  input  logic       sysck_wr,
  input  logic       sysck_val,
  input  logic       hfosc_wr,
  input  logic       hfosc_val,
  input  logic       hfsrc_wr,
  input  logic       hfsrc_val,
  input  logic       irq_pend,
  input  logic       stop_rel,
  input  logic       tb_clk,
  output logic [3:0] mode,
  output logic       cpu_clk_en,
  output logic       periph_clk_en,
  output logic       hf_osc_en,
  output logic       lf_osc_en,
  output logic       hf_src_ext,
  output logic       warm_busy
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  logic       tb_fall, warm_load, warm_done;
  logic       src_en;
  mode_e      st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  pmc_tb_edge #(.SYNC_STAGES(TB_SYNC)) u_tb_edge (
    .clk(clk), .rst_n(rst_i_n), .tb_clk(tb_clk), .tb_fall(tb_fall)
  );

  pmc_warmup #(.WARM_CYCLES(WARM_CYCLES)) u_warm (
    .clk(clk), .rst_n(rst_i_n), .load(warm_load),
    .busy(warm_busy), .done(warm_done)
  );

  pmc_fsm u_fsm (
    .clk(clk), .rst_n(rst_i_n),
    .wr_idle(wr_idle), .wr_tbhalt(wr_tbhalt), .wr_stop(wr_stop),
    .lfosc_wr(lfosc_wr), .lfosc_val(lfosc_val),
    .sysck_wr(sysck_wr), .sysck_val(sysck_val),
    .hfosc_wr(hfosc_wr), .hfosc_val(hfosc_val),
    .irq_pend(irq_pend), .stop_rel(stop_rel), .tb_fall(tb_fall),
    .warm_done(warm_done), .warm_load(warm_load), .st(st),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .hf_osc_en(hf_osc_en), .lf_osc_en(lf_osc_en)
  );

  assign warm_busy = (st == M_WARM);
  assign mode      = st;

  assign src_en = hfsrc_wr & ((st == M_N1) | (st == M_N2));
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    hf_src_ext <= 1'b0;
    else if (src_en) hf_src_ext <= hfsrc_val;
  end

  // R8: source select frozen outside the fast run modes
  p_src_hold_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    !((mode == 4'd1) || (mode == 4'd2)) |=> $stable(hf_src_ext));
endmodule

// File: tb/pwr_mode_ctl_tb_top.sv
module pwr_mode_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_idle = 0, wr_tbhalt = 0, wr_stop = 0;
  logic lfosc_wr = 0, lfosc_val = 0, sysck_wr = 0, sysck_val = 0;
  logic hfosc_wr = 0, hfosc_val = 0, hfsrc_wr = 0, hfsrc_val = 0;
  logic irq_pend = 0, stop_rel = 0, tb_clk = 1;
  logic [3:0] mode;
  logic cpu_clk_en, periph_clk_en, hf_osc_en, lf_osc_en, hf_src_ext, warm_busy;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctl #(.WARM_CYCLES(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_idle(wr_idle), .wr_tbhalt(wr_tbhalt), .wr_stop(wr_stop),
    .lfosc_wr(lfosc_wr), .lfosc_val(lfosc_val),
    .sysck_wr(sysck_wr), .sysck_val(sysck_val),
    .hfosc_wr(hfosc_wr), .hfosc_val(hfosc_val),
    .hfsrc_wr(hfsrc_wr), .hfsrc_val(hfsrc_val),
    .irq_pend(irq_pend), .stop_rel(stop_rel), .tb_clk(tb_clk),
    .mode(mode), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .hf_osc_en(hf_osc_en), .lf_osc_en(lf_osc_en),
    .hf_src_ext(hf_src_ext), .warm_busy(warm_busy)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_all();
    wr_idle = 0; wr_tbhalt = 0; wr_stop = 0;
    lfosc_wr = 0; sysck_wr = 0; hfosc_wr = 0; hfsrc_wr = 0;
    irq_pend = 0; stop_rel = 0;
  endtask

  // outputs packed as {cpu, periph, hf, lf}
  function automatic int gates();
    return {cpu_clk_en, periph_clk_en, hf_osc_en, lf_osc_en};
  endfunction

  task automatic t_reset();
    rst_n = 0; clr_all(); step(3);
    chk("R1 mode in reset", mode, 0);
    chk("R1 busy in reset", warm_busy, 1);
    chk("R10 gates in warm-up", gates(), 4'b0010);
    rst_n = 1;
    step(W + 1);
    chk("R1 busy on last warm cycle", warm_busy, 1);
    step(1);
    chk("R1 mode after warm-up", mode, 1);
    chk("R1 busy cleared", warm_busy, 0);
    chk("R10 gates NORMAL1", gates(), 4'b1110);
  endtask

  task automatic t_idle();
    wr_idle = 1; step(1); clr_all();
    chk("R2 NORMAL1 idle", mode, 6);
    chk("R10 gates IDLE1", gates(), 4'b0110);
    irq_pend = 1; step(1); clr_all();
    chk("R2 IDLE1 wake", mode, 1);
    lfosc_wr = 1; lfosc_val = 1; step(1); clr_all();
    chk("R4 slow osc on", mode, 2);
    wr_idle = 1; step(1); clr_all();
    chk("R2 NORMAL2 idle", mode, 7);
    irq_pend = 1; step(1); clr_all();
    chk("R2 IDLE2 wake", mode, 2);
    lfosc_wr = 1; lfosc_val = 0; step(1); clr_all();
    chk("R4 slow osc off", mode, 1);
  endtask

  task automatic t_tbhalt();
    wr_tbhalt = 1; step(1); clr_all();
    chk("R3 NORMAL1 halt", mode, 5);
    irq_pend = 1; step(1); clr_all();
    chk("R3 irq ignored in IDLE0", mode, 5);
    tb_clk = 0; step(2);
    chk("R3 not yet released", mode, 5);
    step(1);
    chk("R3 IDLE0 release on fall", mode, 1);
    tb_clk = 1; step(3);
  endtask

  task automatic t_gears();
    lfosc_wr = 1; lfosc_val = 1; step(1); clr_all();
    wr_tbhalt = 1; step(1); clr_all();
    chk("R9 halt ignored in NORMAL2", mode, 2);
    sysck_wr = 1; sysck_val = 1; step(1); clr_all();
    chk("R5 to SLOW2", mode, 4);
    wr_idle = 1; step(1); clr_all();
    chk("R9 idle ignored in SLOW2", mode, 4);
    hfosc_wr = 1; hfosc_val = 0; step(1); clr_all();
    chk("R5 to SLOW1", mode, 3);
    chk("R10 gates SLOW1", gates(), 4'b1101);
    wr_idle = 1; step(1); clr_all();
    chk("R2 SLOW1 idle", mode, 9);
    chk("R10 gates SLEEP1", gates(), 4'b0101);
    irq_pend = 1; step(1); clr_all();
    chk("R2 SLEEP1 wake", mode, 3);
    wr_tbhalt = 1; step(1); clr_all();
    chk("R3 SLOW1 halt", mode, 8);
    tb_clk = 0; step(3);
    chk("R3 SLEEP0 release", mode, 3);
    tb_clk = 1; step(3);
    hfsrc_wr = 1; hfsrc_val = 1; step(1); clr_all();
    chk("R8 source write ignored in SLOW1", hf_src_ext, 0);
    hfosc_wr = 1; hfosc_val = 1; step(1); clr_all();
    chk("R5 back to SLOW2", mode, 4);
    sysck_wr = 1; sysck_val = 0; step(1); clr_all();
    chk("R5 back to NORMAL2", mode, 2);
    hfsrc_wr = 1; hfsrc_val = 1; step(1); clr_all();
    chk("R8 source write in NORMAL2", hf_src_ext, 1);
  endtask

  task automatic t_stop_fast();
    wr_stop = 1; wr_idle = 1; lfosc_wr = 1; lfosc_val = 0; step(1); clr_all();
    chk("R9 stop wins", mode, 10);
    chk("R10 gates STOP", gates(), 4'b0000);
    hfsrc_wr = 1; hfsrc_val = 0; step(1); clr_all();
    chk("R8 source write ignored in STOP", hf_src_ext, 1);
    stop_rel = 1; step(1); clr_all();
    chk("R6 warm-up entered", mode, 0);
    chk("R10 slow osc kept in warm-up", lf_osc_en, 1);
    step(W - 1);
    chk("R6 still warming", warm_busy, 1);
    step(1);
    chk("R6 back to NORMAL2", mode, 2);
    lfosc_wr = 1; lfosc_val = 0; step(1); clr_all();
    wr_tbhalt = 1; wr_idle = 1; step(1); clr_all();
    chk("R9 halt before idle", mode, 5);
    tb_clk = 0; step(3); tb_clk = 1; step(3);
    wr_stop = 1; step(1); clr_all();
    stop_rel = 1; step(1); clr_all();
    step(W);
    chk("R6 back to NORMAL1", mode, 1);
  endtask

  task automatic t_stop_slow();
    lfosc_wr = 1; lfosc_val = 1; step(1); clr_all();
    sysck_wr = 1; sysck_val = 1; step(1); clr_all();
    wr_stop = 1; step(1); clr_all();
    chk("R6 stop from SLOW2", mode, 10);
    irq_pend = 1; step(1); clr_all();
    chk("R9 irq ignored in STOP", mode, 10);
    stop_rel = 1; step(1); clr_all();
    chk("R7 SLOW2 stop returns to SLOW1", mode, 3);
    chk("R7 no warm-up", warm_busy, 0);
    wr_stop = 1; step(1); clr_all();
    stop_rel = 1; step(1); clr_all();
    chk("R7 SLOW1 stop returns to SLOW1", mode, 3);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_tbhalt();
    t_gears();
    t_stop_fast();
    t_stop_slow();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule